// File: doc/BRIEF.md
# Reset-Sequenced Core Clock Generator

This block takes a free-running system clock and produces a slower core clock for a sequencer. Its phase is tied to the moment an external active-low reset is released. While the external reset is held low, the divider and the sequencer stay idle. Configuration can still be written over a write-only SPI port during that time. When the reset is released, the input passes through a two-flop synchronizer. The core clock then starts at a fixed number of system-clock edges after the release, so every start-up has the same phase.

There are two reset domains. The external reset clears only the divider and the sequencer state. The power-on reset also returns the configuration bank to its defaults. A one-cycle enable strobe marks each rising edge of the core clock, so downstream logic can stay on the system clock. A running flag tells the rest of the chip that the sequencer is active.

Top module: `coreclk_seq_top`

## Requirements
- R1: While `ext_rst_n` or `por_n` is low, `core_clk`, `core_ce` and `seq_running` are 0. After a power-on reset, `live_cfg` reads 0x00 and the divide ratio is 4.
- R2: Number the first `sys_clk` rising edge at which `ext_rst_n` (with `por_n` high) is sampled high as edge 1. `core_clk` stays low through edge 3 and makes its first rising transition at edge 4.
- R3: Once started, `core_clk` is high for N/2 system cycles and then low for N/2 system cycles, where N is the stored divide ratio.
- R4: `core_ce` is high for exactly the one system cycle that begins with each rising transition of `core_clk`, and is low at all other times.
- R5: `seq_running` rises together with the first `core_clk` rising transition. It drops, together with `core_clk` and `core_ce`, as soon as either reset input goes low, without waiting for a clock edge.
- R6: Asserting `ext_rst_n` leaves the configuration bank unchanged. `live_cfg` and the divide ratio keep their values across it.
- R7: Asserting `por_n` returns `live_cfg` to 0x00 and the divide ratio to 4.
- R8: An SPI frame is written with `spi_cs_n` low and uses mode 0: `spi_mosi` is sampled on the rising edge of `spi_sck`, MSB first. A frame is 16 bits, an 8-bit address followed by 8-bit data. A frame with fewer than 16 bits before `spi_cs_n` rises writes nothing.
- R9: Address 0x00 holds the divide ratio. A written value has bit 0 cleared and is raised to 2 if the result is below 2. The write is accepted only while `seq_running` is low and is ignored while it is high.
- R10: Address 0x01 is a live setting, writable at any time and shown on `live_cfg`. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including configuration |
| ext_rst_n | input | 1 | External reset, active low, clears divider and sequencer only |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in, MSB first |
| core_clk | output | 1 | Divided core clock |
| core_ce | output | 1 | One-cycle strobe on each core clock rise |
| seq_running | output | 1 | Sequencer active flag |
| live_cfg | output | 8 | Live configuration setting (address 0x01) |

## Verification
A reference model in the bench predicts `core_clk`, `core_ce` and `seq_running` on every system cycle. The model knows only the number of cycles since the synchronized release and the ratio it was told to expect.

A synchronizer or start-delay fault shifts the first core edge. A bad half-period counter or a wrongly accepted divide write distorts the waveform. Either fault shows as a mismatch within one core period. A configuration register that the external reset wrongly clears, or that a partial or misaddressed frame corrupts, shows on `live_cfg` right after the operation. It also shows in the period of the next run.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_DIV  = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_LIVE = 8'h01;
    localparam logic [DATA_W-1:0] DIV_DEFAULT  = 8'd4;
    localparam logic [DATA_W-1:0] LIVE_DEFAULT = 8'h00;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/cclk_rst_sync.sv
module cclk_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rel_o = chain_q[STAGES-1];

    // R2
    sync_chain_chk: assert property (@(posedge clk) disable iff (!arst_n)
        chain_q[STAGES-1] |-> $past(chain_q[STAGES-2]));
endmodule

// File: rtl/cclk_spi_cfg.sv
module cclk_spi_cfg
    import cclk_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter logic [DW-1:0] DIV_RST  = DIV_DEFAULT,
    parameter logic [DW-1:0] LIVE_RST = LIVE_DEFAULT
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          run_i,
    input  logic          sck_i,
    input  logic          cs_n_i,
    input  logic          mosi_i,
    output logic [DW-1:0] div_o,
    output logic [DW-1:0] live_o
);
    localparam int FRAME_BITS = AW + DW;
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [2:0]            s1;
        logic [2:0]            s2;
        logic                  sck_prev;
        logic [FRAME_BITS-2:0] shift;
        logic [CNT_W-1:0]      bits;
        logic [DW-1:0]         div;
        logic [DW-1:0]         live;
    } spi_st_t;

    spi_st_t st_d, st_q;
    logic                  sck_s, cs_n_s, mosi_s;
    logic [FRAME_BITS-1:0] word;
    logic [AW-1:0]         waddr;
    logic [DW-1:0]         wdata;
    logic [DW-1:0]         div_fix;

    always_comb begin
        st_d = st_q;
        sck_s  = st_q.s2[2];
        cs_n_s = st_q.s2[1];
        mosi_s = st_q.s2[0];
        st_d.s1 = {sck_i, cs_n_i, mosi_i};
        st_d.s2 = st_q.s1;
        st_d.sck_prev = sck_s;
        word  = {st_q.shift, mosi_s};
        waddr = word[FRAME_BITS-1:DW];
        wdata = word[DW-1:0];
        div_fix = {wdata[DW-1:1], 1'b0};
        if (div_fix < DW'(2)) div_fix = DW'(2);
        if (cs_n_s) begin
            st_d.bits = '0;
        end else if (sck_s && !st_q.sck_prev) begin
            if (st_q.bits == CNT_W'(FRAME_BITS - 1)) begin
                st_d.bits = '0;
                if (waddr == ADDR_DIV && !run_i) st_d.div  = div_fix;
                if (waddr == ADDR_LIVE)          st_d.live = wdata;
            end else begin
                st_d.shift = {st_q.shift[FRAME_BITS-3:0], mosi_s};
                st_d.bits  = st_q.bits + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.s1       <= 3'b010;
            st_q.s2       <= 3'b010;
            st_q.sck_prev <= 1'b0;
            st_q.shift    <= '0;
            st_q.bits     <= '0;
            st_q.div      <= DIV_RST;
            st_q.live     <= LIVE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o  = st_q.div;
    assign live_o = st_q.live;

    // R9
    div_legal_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.div[0] == 1'b0) && (st_q.div >= DW'(2)));
    // R9
    div_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
        run_i |=> $stable(st_q.div));
endmodule

// File: rtl/cclk_core_div.sv
module cclk_core_div
    import cclk_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          rel_i,
    input  logic [DW-1:0] div_i,
    output logic          core_clk_o,
    output logic          core_ce_o,
    output logic          run_o
);
    typedef struct packed {
        logic          dly;
        logic          run;
        logic          cclk;
        logic          ce;
        logic [DW-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DW-1:0] half;

    always_comb begin
        st_d    = st_q;
        st_d.ce = 1'b0;
        half    = div_i >> 1;
        if (!rel_i) begin
            st_d = '0;
        end else if (!st_q.run) begin
            if (st_q.dly) begin
                st_d.run  = 1'b1;
                st_d.cclk = 1'b1;
                st_d.ce   = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.dly = 1'b1;
            end
        end else if (st_q.cnt == half - DW'(1)) begin
            st_d.cnt  = '0;
            st_d.cclk = !st_q.cclk;
            st_d.ce   = !st_q.cclk;
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign core_clk_o = st_q.cclk;
    assign core_ce_o  = st_q.ce;
    assign run_o      = st_q.run;

    // R4
    ce_on_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
        st_q.ce |-> (st_q.cclk && !$past(st_q.cclk)));
    // R5
    clk_needs_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
        st_q.cclk |-> st_q.run);
    // R2
    start_delay_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(st_q.run) |-> ($past(rel_i) && $past(rel_i, 2)));
endmodule

// File: rtl/coreclk_seq_top.sv
module coreclk_seq_top
    import cclk_pkg::*;
(
    input  logic              sys_clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              core_clk,
    output logic              core_ce,
    output logic              seq_running,
    output logic [DATA_W-1:0] live_cfg
);
    logic              rst_core_n;
    logic              rel;
    logic [DATA_W-1:0] div_val;

    assign rst_core_n = por_n & ext_rst_n;

    cclk_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (sys_clk),
        .arst_n (rst_core_n),
        .rel_o  (rel)
    );

    cclk_spi_cfg #(.AW(ADDR_W), .DW(DATA_W)) u_cfg (
        .clk    (sys_clk),
        .por_n  (por_n),
        .run_i  (seq_running),
        .sck_i  (spi_sck),
        .cs_n_i (spi_cs_n),
        .mosi_i (spi_mosi),
        .div_o  (div_val),
        .live_o (live_cfg)
    );

    cclk_core_div #(.DW(DATA_W)) u_div (
        .clk        (sys_clk),
        .arst_n     (rst_core_n),
        .rel_i      (rel),
        .div_i      (div_val),
        .core_clk_o (core_clk),
        .core_ce_o  (core_ce),
        .run_o      (seq_running)
    );
endmodule

// File: tb/tb_coreclk_seq_top.sv
module tb_coreclk_seq_top;
    logic sys_clk = 1'b0;
    logic por_n = 1'b0, ext_rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic core_clk, core_ce, seq_running;
    logic [7:0] live_cfg;

    int total = 0, failed = 0;
    int model_n = 4;
    int model_live = 0;
    int since = -1;
    bit prev_in = 1'b0;
    bit done = 1'b0;

    always #4 sys_clk = ~sys_clk;

    coreclk_seq_top dut (
        .sys_clk(sys_clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .core_clk(core_clk), .core_ce(core_ce), .seq_running(seq_running),
        .live_cfg(live_cfg)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: cycles since synchronized release
    always @(posedge sys_clk) begin
        bit now_in;
        now_in = ext_rst_n & por_n;
        if (now_in && prev_in) since++;
        else since = -1;
        prev_in = now_in;
    end

    always @(negedge sys_clk) begin
        int t;
        bit e_clk, e_ce, e_run;
        t = since - 2;
        e_run = (t >= 0);
        e_clk = e_run && ((t % model_n) < model_n / 2);
        e_ce  = e_run && ((t % model_n) == 0);
        if (!(ext_rst_n && por_n)) begin
            e_run = 0; e_clk = 0; e_ce = 0;
        end
        if (!done) begin
            chk(core_clk == e_clk, "R3", "core_clk", int'(core_clk), int'(e_clk));
            chk(core_ce == e_ce, "R4", "core_ce", int'(core_ce), int'(e_ce));
            chk(seq_running == e_run, "R5", "seq_running", int'(seq_running), int'(e_run));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge sys_clk);
        #2;
    endtask

    task automatic spi_bits(logic [15:0] w, int nbits);
        spi_cs_n = 1'b0;
        cyc(4);
        for (int i = 15; i > 15 - nbits; i--) begin
            spi_mosi = w[i];
            cyc(4);
            spi_sck = 1'b1;
            cyc(4);
            spi_sck = 1'b0;
        end
        cyc(4);
        spi_cs_n = 1'b1;
        cyc(8);
    endtask

    task automatic spi_write(logic [7:0] a, logic [7:0] d);
        spi_bits({a, d}, 16);
    endtask

    function automatic int fix_div(int d);
        int v;
        v = d & 8'hFE;
        if (v < 2) v = 2;
        return v;
    endfunction

    task automatic release_and_check_start();
        @(posedge sys_clk); #2;
        ext_rst_n = 1'b1;
        repeat (3) @(posedge sys_clk);
        @(negedge sys_clk);
        chk(core_clk == 1'b0, "R2", "core_clk before edge 4", int'(core_clk), 0);
        @(posedge sys_clk);
        @(negedge sys_clk);
        chk(core_clk == 1'b1, "R2", "core_clk after edge 4", int'(core_clk), 1);
        chk(seq_running == 1'b1, "R5", "running at first edge", int'(seq_running), 1);
    endtask

    task automatic assert_ext();
        @(posedge sys_clk); #2;
        ext_rst_n = 1'b0;
        #1;
        chk(seq_running == 1'b0, "R5", "running drops at once", int'(seq_running), 0);
        chk(core_clk == 1'b0, "R5", "core_clk drops at once", int'(core_clk), 0);
        cyc(3);
    endtask

    initial begin
        #(8 * 150000);
        total++;
        failed++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        cyc(5);
        por_n = 1'b1;
        cyc(4);
        // R1 reset state
        chk(live_cfg == 8'h00, "R1", "live_cfg default", int'(live_cfg), 0);
        chk(seq_running == 1'b0, "R1", "running in reset", int'(seq_running), 0);
        chk(core_clk == 1'b0, "R1", "core_clk in reset", int'(core_clk), 0);

        // default ratio 4
        release_and_check_start();
        cyc(40);

        // R10 live write during run, R9 divider write ignored while running
        spi_write(8'h01, 8'hA5);
        model_live = 8'hA5;
        chk(live_cfg == 8'hA5, "R10", "live write while running", int'(live_cfg), model_live);
        spi_write(8'h00, 8'h06);
        cyc(40);

        // R5 async clear, R6 configuration kept
        assert_ext();
        chk(live_cfg == 8'hA5, "R6", "live kept over ext reset", int'(live_cfg), model_live);
        release_and_check_start();
        cyc(30);
        assert_ext();

        // R9 ratio write in reset, R8 partial frame ignored, R10 unknown address
        spi_write(8'h00, 8'h07);
        model_n = fix_div(8'h07);
        spi_bits({8'h01, 8'h3C}, 8);
        chk(live_cfg == 8'hA5, "R8", "partial frame ignored", int'(live_cfg), model_live);
        spi_bits({8'h01, 8'h3C}, 15);
        chk(live_cfg == 8'hA5, "R8", "15-bit frame ignored", int'(live_cfg), model_live);
        spi_write(8'h55, 8'h33);
        chk(live_cfg == 8'hA5, "R10", "unknown address ignored", int'(live_cfg), model_live);
        release_and_check_start();
        cyc(60);

        // R9 lower clamp: 0x01 -> 2
        assert_ext();
        spi_write(8'h00, 8'h01);
        model_n = fix_div(8'h01);
        release_and_check_start();
        cyc(30);

        // R7 power-on reset while running
        @(posedge sys_clk); #2;
        por_n = 1'b0;
        #1;
        chk(seq_running == 1'b0, "R5", "running drops on por", int'(seq_running), 0);
        cyc(3);
        model_n = 4;
        model_live = 0;
        chk(live_cfg == 8'h00, "R7", "live restored by por", int'(live_cfg), 0);
        ext_rst_n = 1'b0;
        por_n = 1'b1;
        cyc(3);
        release_and_check_start();
        cyc(40);

        // R9 zero clamps to 2
        assert_ext();
        spi_write(8'h00, 8'h00);
        model_n = fix_div(8'h00);
        spi_write(8'h01, 8'h5A);
        model_live = 8'h5A;
        chk(live_cfg == 8'h5A, "R10", "live write in reset", int'(live_cfg), model_live);
        release_and_check_start();
        cyc(20);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule